// File: doc/BRIEF.md
# Dual-Operand Prefetch Address Generator

This block forms the two data-read addresses that a multiply-accumulate style instruction fetches in one cycle: one into the X data space and one into the Y data space. It owns four pointer registers and one shared offset register. Pointers 8 and 9 serve the X path only, and pointers 10 and 11 serve the Y path only. On each start strobe, each path reads its selected pointer and applies its own addressing-mode code. It then reports the effective address, the pointer value after the operation, and two error flags: illegal mode and address out of window.

Both paths work in the same cycle and do not depend on each other. Their results appear together one clock after the strobe, marked by a single-cycle valid pulse, and they are held until the next strobe. A load port writes any pointer or the offset register.

The instruction decoder drives the select and mode fields. The operand fetch logic consumes the addresses. The write-back results let the decoder see each post-modified pointer.

Top module: `dual_prefetch_agu`

## Requirements
- R1: The X path uses pointer 8 when `x_sel`=0 and pointer 9 when `x_sel`=1. The Y path uses pointer 10 when `y_sel`=0 and pointer 11 when `y_sel`=1. Both paths are evaluated and updated in the same cycle without interacting.
- R2: `valid` is high for exactly the one cycle after a cycle in which `start` is high. The address, write-back and flag outputs keep their values until the next start.
- R3: Mode code 0 (plain indirect) gives address = pointer and write-back = pointer, and leaves the pointer unchanged.
- R4: Mode codes 1, 2 and 3 (post-modify) give address = old pointer and write-back = pointer + 2, + 4 or + 6 respectively. The pointer takes the write-back value.
- R5: Mode code 4 (indexed) gives address = pointer + offset register, computed as unsigned 16-bit arithmetic with wraparound. Write-back = pointer, and the pointer is unchanged. This applies only with select 1 (pointer 9 or 11).
- R6: Mode code 4 with select 0 (pointer 8 or 10) is illegal, and so are codes 5 to 7. An illegal request sets that path's illegal flag and clears its range flag. Address and write-back both equal the pointer, and the pointer is unchanged.
- R7: The range flag is set when the pre-modification address or the post-modification value lies outside that path's inclusive window (default X 0x0800..0x17FF, Y 0x1800..0x1FFF). A flagged post-modify leaves the pointer unchanged, and its write-back shows the unchanged pointer.
- R8: Bit 0 of every address, write-back value and loaded pointer is forced to 0.
- R9: When `ld_en` is high, `ld_sel` 0..3 loads pointer 8..11 and `ld_sel` 4 loads the offset register. Codes 5..7 change nothing. A load takes precedence over a post-modify of the same pointer in the same cycle.
- R10: Reset clears `valid` and all flags. It sets pointers 8 and 9 to the X low bound, pointers 10 and 11 to the Y low bound, and the offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate both paths this cycle |
| x_sel | input | 1 | X pointer select (0: pointer 8, 1: pointer 9) |
| x_mode | input | 3 | X addressing-mode code |
| y_sel | input | 1 | Y pointer select (0: pointer 10, 1: pointer 11) |
| y_mode | input | 3 | Y addressing-mode code |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 3 | Load target (0..3 pointers, 4 offset) |
| ld_data | input | 16 | Load value |
| valid | output | 1 | Results present (one cycle after start) |
| x_addr | output | 16 | X effective address |
| x_wb | output | 16 | X pointer value after the operation |
| x_illegal | output | 1 | X request illegal |
| x_range_err | output | 1 | X address outside the X window |
| y_addr | output | 16 | Y effective address |
| y_wb | output | 16 | Y pointer value after the operation |
| y_illegal | output | 1 | Y request illegal |
| y_range_err | output | 1 | Y address outside the Y window |

## Verification
A wrong pointer value inside the block shows up at the ports on the very next operation that reads that pointer. A plain fetch one cycle later exposes the value directly in `x_addr` or `y_addr`. Wrong precedence between a post-modify and a load, or a modify that is not blocked after an error, therefore shows one operation later and not in the result of the faulty operation itself. The bench tracks every pointer and the offset in its scoreboard, so a divergence is reported on the first valid pulse where it matters.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int AW    = 16;
    localparam int NPTR  = 4;
    localparam int NLANE = 2;
    localparam int LDW   = 3;

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [2:0] {
        AM_IND   = 3'd0,
        AM_POST2 = 3'd1,
        AM_POST4 = 3'd2,
        AM_POST6 = 3'd3,
        AM_INDEX = 3'd4
    } amode_e;

    localparam logic [LDW-1:0] LD_OFS = 3'd4;

    typedef struct packed {
        addr_t ea;
        addr_t wb;
        logic  upd;
        logic  illegal;
        logic  range_err;
    } lane_res_t;

    function automatic addr_t word_align(addr_t a);
        return {a[AW-1:1], 1'b0};
    endfunction

    function automatic addr_t post_step(logic [2:0] m);
        case (m)
            AM_POST2: return addr_t'(2);
            AM_POST4: return addr_t'(4);
            AM_POST6: return addr_t'(6);
            default:  return '0;
        endcase
    endfunction

    function automatic logic in_window(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/agu_lane.sv
module agu_lane
    import agu_pkg::*;
#(
    parameter addr_t LO = 16'h0800,
    parameter addr_t HI = 16'h17FF
) (
    input  addr_t      ptr_even,
    input  addr_t      ptr_odd,
    input  logic       sel,
    input  logic [2:0] mode,
    input  addr_t      ofs,
    output lane_res_t  res
);

    addr_t base;
    addr_t stepped;
    addr_t indexed;

    assign base    = sel ? ptr_odd : ptr_even;
    assign stepped = word_align(base + post_step(mode));
    assign indexed = word_align(base + ofs);

    always_comb begin
        res.ea        = base;
        res.wb        = base;
        res.upd       = 1'b0;
        res.illegal   = 1'b0;
        res.range_err = 1'b0;
        case (mode)
            AM_IND: begin
                res.range_err = !in_window(base, LO, HI);
            end
            AM_POST2, AM_POST4, AM_POST6: begin
                if (!in_window(base, LO, HI) || !in_window(stepped, LO, HI)) begin
                    res.range_err = 1'b1;
                end else begin
                    res.wb  = stepped;
                    res.upd = 1'b1;
                end
            end
            AM_INDEX: begin
                if (sel) begin
                    res.ea        = indexed;
                    res.range_err = !in_window(indexed, LO, HI);
                end else begin
                    res.illegal = 1'b1;
                end
            end
            default: begin
                res.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/agu_ptr_file.sv
module agu_ptr_file
    import agu_pkg::*;
#(
    parameter addr_t X_INIT = 16'h0800,
    parameter addr_t Y_INIT = 16'h1800
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_en,
    input  logic [LDW-1:0]        ld_sel,
    input  addr_t                 ld_data,
    input  logic [NLANE-1:0]      upd,
    input  logic [NLANE-1:0]      sel,
    input  addr_t [NLANE-1:0]     upd_val,
    output addr_t [NPTR-1:0]      ptr,
    output addr_t                 ofs
);

    addr_t [NPTR-1:0] ptr_q;
    addr_t            ofs_q;

    genvar i;
    generate
        for (i = 0; i < NPTR; i++) begin : g_ptr
            localparam int    LANE = i / 2;
            localparam logic  SUB  = logic'(i % 2);
            localparam addr_t INIT = (LANE == 0) ? X_INIT : Y_INIT;

            logic ld_hit;
            logic mod_hit;
            assign ld_hit  = ld_en && (ld_sel == LDW'(i));
            assign mod_hit = upd[LANE] && (sel[LANE] == SUB);

            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr_q[i] <= word_align(INIT);
                end else if (ld_hit) begin
                    ptr_q[i] <= word_align(ld_data);
                end else if (mod_hit) begin
                    ptr_q[i] <= upd_val[LANE];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
        end else if (ld_en && (ld_sel == LD_OFS)) begin
            ofs_q <= ld_data;
        end
    end

    assign ptr = ptr_q;
    assign ofs = ofs_q;

endmodule

// File: rtl/dual_prefetch_agu.sv
module dual_prefetch_agu
    import agu_pkg::*;
#(
    parameter addr_t X_LO = 16'h0800,
    parameter addr_t X_HI = 16'h17FF,
    parameter addr_t Y_LO = 16'h1800,
    parameter addr_t Y_HI = 16'h1FFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        x_sel,
    input  logic [2:0]  x_mode,
    input  logic        y_sel,
    input  logic [2:0]  y_mode,
    input  logic        ld_en,
    input  logic [2:0]  ld_sel,
    input  logic [15:0] ld_data,
    output logic        valid,
    output logic [15:0] x_addr,
    output logic [15:0] x_wb,
    output logic        x_illegal,
    output logic        x_range_err,
    output logic [15:0] y_addr,
    output logic [15:0] y_wb,
    output logic        y_illegal,
    output logic        y_range_err
);

    addr_t [NPTR-1:0]  ptr;
    addr_t             ofs;
    logic [NLANE-1:0]  lane_sel;
    logic [2:0]        lane_mode [NLANE];
    lane_res_t         lane_res  [NLANE];
    lane_res_t         res_q     [NLANE];
    logic [NLANE-1:0]  lane_upd;
    addr_t [NLANE-1:0] lane_wb;
    logic              valid_q;

    assign lane_sel[0]  = x_sel;
    assign lane_sel[1]  = y_sel;
    assign lane_mode[0] = x_mode;
    assign lane_mode[1] = y_mode;

    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            localparam addr_t LO = (g == 0) ? X_LO : Y_LO;
            localparam addr_t HI = (g == 0) ? X_HI : Y_HI;

            agu_lane #(.LO(LO), .HI(HI)) u_lane (
                .ptr_even (ptr[2*g]),
                .ptr_odd  (ptr[2*g+1]),
                .sel      (lane_sel[g]),
                .mode     (lane_mode[g]),
                .ofs      (ofs),
                .res      (lane_res[g])
            );

            assign lane_upd[g] = start && lane_res[g].upd;
            assign lane_wb[g]  = lane_res[g].wb;

            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q[g] <= '0;
                end else if (start) begin
                    res_q[g] <= lane_res[g];
                end
            end
        end
    endgenerate

    agu_ptr_file #(.X_INIT(X_LO), .Y_INIT(Y_LO)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .upd     (lane_upd),
        .sel     (lane_sel),
        .upd_val (lane_wb),
        .ptr     (ptr),
        .ofs     (ofs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= start;
        end
    end

    assign valid       = valid_q;
    assign x_addr      = res_q[0].ea;
    assign x_wb        = res_q[0].wb;
    assign x_illegal   = res_q[0].illegal;
    assign x_range_err = res_q[0].range_err;
    assign y_addr      = res_q[1].ea;
    assign y_wb        = res_q[1].wb;
    assign y_illegal   = res_q[1].illegal;
    assign y_range_err = res_q[1].range_err;

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
    parameter logic [15:0] X_LO = 16'h0800,
    parameter logic [15:0] X_HI = 16'h17FF,
    parameter logic [15:0] Y_LO = 16'h1800,
    parameter logic [15:0] Y_HI = 16'h1FFF
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        valid,
    input logic [15:0] x_addr,
    input logic [15:0] x_wb,
    input logic        x_illegal,
    input logic        x_range_err,
    input logic [15:0] y_addr,
    input logic [15:0] y_wb,
    input logic        y_illegal,
    input logic        y_range_err
);

    // R2
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);

    // R2
    valid_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(start));

    // R2
    results_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(x_addr) && $stable(y_addr) && $stable(x_wb) && $stable(y_wb)));

    // R8
    word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (x_addr[0] == 1'b0 && y_addr[0] == 1'b0 && x_wb[0] == 1'b0 && y_wb[0] == 1'b0));

    // R6
    x_illegal_passive_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && x_illegal) |-> (!x_range_err && x_wb == x_addr));

    // R6
    y_illegal_passive_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && y_illegal) |-> (!y_range_err && y_wb == y_addr));

    // R7
    x_window_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !x_range_err && !x_illegal) |->
            (x_addr >= X_LO && x_addr <= X_HI && x_wb >= X_LO && x_wb <= X_HI));

    // R7
    y_window_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !y_range_err && !y_illegal) |->
            (y_addr >= Y_LO && y_addr <= Y_HI && y_wb >= Y_LO && y_wb <= Y_HI));

endmodule

bind dual_prefetch_agu agu_chk #(
    .X_LO(X_LO), .X_HI(X_HI), .Y_LO(Y_LO), .Y_HI(Y_HI)
) u_agu_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .valid       (valid),
    .x_addr      (x_addr),
    .x_wb        (x_wb),
    .x_illegal   (x_illegal),
    .x_range_err (x_range_err),
    .y_addr      (y_addr),
    .y_wb        (y_wb),
    .y_illegal   (y_illegal),
    .y_range_err (y_range_err)
);

// File: tb/dual_prefetch_agu_test.sv
module dual_prefetch_agu_test;

    localparam logic [15:0] XL = 16'h0800, XH = 16'h17FF;
    localparam logic [15:0] YL = 16'h1800, YH = 16'h1FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        x_sel = 1'b0, y_sel = 1'b0;
    logic [2:0]  x_mode = '0, y_mode = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic        valid;
    logic [15:0] x_addr, x_wb, y_addr, y_wb;
    logic        x_illegal, x_range_err, y_illegal, y_range_err;

    always #2 clk = ~clk;

    dual_prefetch_agu uut (
        .clk(clk), .rst(rst), .start(start),
        .x_sel(x_sel), .x_mode(x_mode), .y_sel(y_sel), .y_mode(y_mode),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .valid(valid),
        .x_addr(x_addr), .x_wb(x_wb), .x_illegal(x_illegal), .x_range_err(x_range_err),
        .y_addr(y_addr), .y_wb(y_wb), .y_illegal(y_illegal), .y_range_err(y_range_err)
    );

    typedef struct packed {
        logic [15:0] ea;
        logic [15:0] wb;
        logic        upd;
        logic        ill;
        logic        err;
    } lexp_t;

    typedef struct {
        lexp_t x;
        lexp_t y;
        string tag;
    } item_t;

    item_t       sb[$];
    item_t       last;
    logic [15:0] mp [4];
    logic [15:0] mofs;
    int          nchecks = 0;
    int          nerrs   = 0;
    bit          done    = 0;

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrs++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic lexp_t lane_model(input logic [15:0] base, input logic sel,
                                         input logic [2:0] mode,
                                         input logic [15:0] lo, input logic [15:0] hi);
        lexp_t r;
        logic [15:0] nxt;
        r = '{ea: base, wb: base, upd: 1'b0, ill: 1'b0, err: 1'b0};
        if (mode == 3'd0) begin
            r.err = (base < lo) || (base > hi);
        end else if (mode <= 3'd3) begin
            nxt = (base + {12'd0, mode, 1'b0}) & 16'hFFFE;
            if (base < lo || base > hi || nxt < lo || nxt > hi) r.err = 1'b1;
            else begin r.wb = nxt; r.upd = 1'b1; end
        end else if (mode == 3'd4 && sel) begin
            r.ea  = (base + mofs) & 16'hFFFE;
            r.err = (r.ea < lo) || (r.ea > hi);
        end else begin
            r.ill = 1'b1;
        end
        return r;
    endfunction

    // Driver: one operation, optionally with a load in the same cycle.
    task automatic op(input string tag, input logic xs, input logic [2:0] xm,
                      input logic ys, input logic [2:0] ym,
                      input logic le = 1'b0, input logic [2:0] ls = 3'd0,
                      input logic [15:0] ld = 16'h0);
        item_t it;
        it.x   = lane_model(mp[{1'b0, xs}], xs, xm, XL, XH);
        it.y   = lane_model(mp[{1'b1, ys}], ys, ym, YL, YH);
        it.tag = tag;
        if (it.x.upd) mp[{1'b0, xs}] = it.x.wb;
        if (it.y.upd) mp[{1'b1, ys}] = it.y.wb;
        if (le) begin
            if (ls < 3'd4) mp[ls[1:0]] = ld & 16'hFFFE;
            else if (ls == 3'd4) mofs = ld;
        end
        sb.push_back(it);
        @(negedge clk);
        start = 1'b1; x_sel = xs; x_mode = xm; y_sel = ys; y_mode = ym;
        ld_en = le; ld_sel = ls; ld_data = ld;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        @(negedge clk);
        chk({tag, " R2"}, "valid after idle", {15'd0, valid}, 16'd0);
    endtask

    task automatic load(input logic [2:0] ls, input logic [15:0] ld);
        if (ls < 3'd4) mp[ls[1:0]] = ld & 16'hFFFE;
        else if (ls == 3'd4) mofs = ld;
        @(negedge clk);
        ld_en = 1'b1; ld_sel = ls; ld_data = ld;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every valid pulse.
    always @(negedge clk) begin
        if (!rst && valid) begin
            if (sb.size() == 0) begin
                nchecks++; nerrs++;
                $display("FAIL R2 unexpected valid: actual 1 expected 0");
            end else begin
                item_t e;
                e = sb.pop_front();
                last = e;
                chk(e.tag, "x_addr", x_addr, e.x.ea);
                chk(e.tag, "x_wb", x_wb, e.x.wb);
                chk(e.tag, "x_illegal", {15'd0, x_illegal}, {15'd0, e.x.ill});
                chk(e.tag, "x_range_err", {15'd0, x_range_err}, {15'd0, e.x.err});
                chk(e.tag, "y_addr", y_addr, e.y.ea);
                chk(e.tag, "y_wb", y_wb, e.y.wb);
                chk(e.tag, "y_illegal", {15'd0, y_illegal}, {15'd0, e.y.ill});
                chk(e.tag, "y_range_err", {15'd0, y_range_err}, {15'd0, e.y.err});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchecks++; nerrs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        mp[0] = XL; mp[1] = XL; mp[2] = YL; mp[3] = YL; mofs = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "valid", {15'd0, valid}, 16'd0);
        chk("R10", "flags", {12'd0, x_illegal, x_range_err, y_illegal, y_range_err}, 16'd0);
        op("R10 R3 reset pointers", 1'b0, 3'd0, 1'b1, 3'd0);
        op("R10 R5 reset offset", 1'b1, 3'd4, 1'b1, 3'd4);
        // R9 loads of all pointers
        load(3'd0, 16'h0900); load(3'd1, 16'h0A00);
        load(3'd2, 16'h1900); load(3'd3, 16'h1A00);
        op("R1 R9 select odd", 1'b1, 3'd0, 1'b1, 3'd0);
        op("R1 R9 select even", 1'b0, 3'd0, 1'b0, 3'd0);
        // R4 post-modify
        op("R4 post2/post4", 1'b0, 3'd1, 1'b0, 3'd2);
        op("R4 post6", 1'b0, 3'd3, 1'b1, 3'd3);
        op("R3 R4 readback", 1'b0, 3'd0, 1'b1, 3'd0);
        op("R3 R4 readback2", 1'b0, 3'd0, 1'b0, 3'd0);
        // R2 outputs held while idle
        repeat (3) @(negedge clk);
        chk("R2 hold", "x_addr", x_addr, last.x.ea);
        chk("R2 hold", "y_addr", y_addr, last.y.ea);
        // R5 indexed
        load(3'd4, 16'h0010);
        op("R5 indexed", 1'b1, 3'd4, 1'b1, 3'd4);
        load(3'd4, 16'hFC00); load(3'd1, 16'h1000);
        op("R5 R7 indexed wrap", 1'b1, 3'd4, 1'b1, 3'd4);
        // R6 illegal requests
        op("R6 indexed on even", 1'b0, 3'd4, 1'b0, 3'd4);
        op("R6 undefined codes", 1'b0, 3'd5, 1'b1, 3'd7);
        op("R6 readback", 1'b0, 3'd0, 1'b0, 3'd0);
        // R7 range violations
        load(3'd0, 16'h17FE); load(3'd3, 16'h1FFC);
        op("R7 post past high", 1'b0, 3'd1, 1'b1, 3'd3);
        op("R7 readback", 1'b0, 3'd0, 1'b1, 3'd0);
        load(3'd2, 16'h2000);
        op("R7 plain outside", 1'b0, 3'd0, 1'b0, 3'd0);
        // R8 odd load is aligned
        load(3'd0, 16'h0901); load(3'd2, 16'h1903);
        op("R8 aligned load", 1'b0, 3'd0, 1'b0, 3'd0);
        // R9 ignored load code
        load(3'd6, 16'hFFFF);
        op("R9 code6 ignored ptr", 1'b0, 3'd0, 1'b1, 3'd0);
        load(3'd4, 16'h0004);
        load(3'd7, 16'h0100);
        op("R9 code7 ignored ofs", 1'b1, 3'd4, 1'b1, 3'd4);
        // R9 load wins over same-cycle post-modify
        op("R9 load vs modify", 1'b0, 3'd1, 1'b0, 3'd2, 1'b1, 3'd0, 16'h0C00);
        op("R9 load wins readback", 1'b0, 3'd0, 1'b0, 3'd0);
        // R1 independent lanes in one cycle
        op("R1 mixed lanes", 1'b1, 3'd2, 1'b0, 3'd4);
        op("R1 mixed readback", 1'b1, 3'd0, 1'b0, 3'd0);
        repeat (3) @(negedge clk);
        chk("R2 drain", "queue", 16'(sb.size()), 16'd0);
        finish_run();
    end

endmodule